// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a parallel flash array. It decides what the host sees when it reads while an internal program or erase job is running. When no job is running, array data passes straight through. While a job runs, the read returns a status word in place of array data. The block also drives a ready/busy output.

The internal program and erase algorithms are not part of the block. They appear only as input events: a start pulse that says which kind of job it is, a completion pulse, a timeout pulse and an erase-suspend level. A reset command leaves the timeout condition and nothing else.

The status word has three active bits. Bit 7 is the polling bit. Bit 6 is the toggle bit. Bit 5 is the timeout bit. Every other bit reads 0.

The controller has six states:

- IDLE: no job is running.
- SETTLE: the job has just started and status is not yet valid.
- BUSY: the job is running.
- TMO: the job has timed out.
- ESUSP: an erase is suspended.
- SPROG: a program was started while an erase is suspended.

The transitions are:

- start: IDLE to SETTLE.
- settle-expire: SETTLE to BUSY.
- complete: SETTLE or BUSY to IDLE.
- time-out: SETTLE, BUSY or SPROG to TMO.
- suspend: BUSY to ESUSP, for an erase only.
- resume: ESUSP to BUSY.
- suspend-program: ESUSP to SPROG.
- suspend-program-complete: SPROG to ESUSP.
- clear: TMO to IDLE, on a reset command.

Top module: `opstat_reporter`

## Requirements
- R1: In IDLE, a read returns `array_data` unchanged. The result appears on `rd_data` one clock after `rd_en` is sampled, and `rd_data` holds between reads.
- R2: During a program job (SETTLE, BUSY, SPROG or TMO), a read at the latched program address returns, on bit 7, the inverse of the latched `op_msb`.
- R3: During a program job, a read at any other address returns 0 on bit 7.
- R4: During an erase job, bit 7 reads 0. In ESUSP, bit 7 reads 1.
- R5: In BUSY, SPROG and TMO, bit 6 inverts on every read. In SETTLE and ESUSP, bit 6 holds its value from read to read.
- R6: An accepted start keeps the block in SETTLE for SETTLE_CYC+1 clocks before it moves to BUSY. A completion or a timeout that arrives during SETTLE is still acted on.
- R7: `ready` is 0 in SETTLE, BUSY and SPROG. It is 1 in IDLE, ESUSP and TMO, and it falls one clock after an accepted start.
- R8: A completion pulse ends the job (SETTLE or BUSY to IDLE). The next read then returns array data.
- R9: A timeout pulse enters TMO. In TMO, bit 5 reads 1 and stays 1 through any completion pulse or start pulse, until `reset_cmd` returns the block to IDLE.
- R10: In ESUSP, a program start enters SPROG. SPROG reports polling bits as in R2 and R3, and a completion returns it to ESUSP. Lowering `erase_susp` resumes the erase in BUSY, with bit 7 at 0.
- R11: `op_start` is ignored in SETTLE, BUSY, SPROG and TMO. The latched address and data bit do not change. `reset_cmd` is ignored outside TMO.
- R12: After reset, `ready` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Job start pulse |
| op_erase | input | 1 | Job kind with the start: 1 is erase, 0 is program |
| op_addr | input | AW | Program address, latched on a program start |
| op_msb | input | 1 | Bit 7 of the datum being programmed |
| op_done | input | 1 | Job completion pulse |
| op_timeout | input | 1 | Job timeout pulse |
| erase_susp | input | 1 | Erase suspend level |
| reset_cmd | input | 1 | Reset command pulse that leaves TMO |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| array_data | input | DW | Array data for the read address |
| rd_data | output | DW | Registered read result |
| ready | output | 1 | 1 when ready, 0 when busy |

## Verification
The bench drives each state transition in turn and reads bit 7 at both the matching address and a different address. A design that compared the wrong address, or forgot to invert, would show a wrong bit 7 at one of the two.

The bench reads twice inside the settle window and twice after it. A toggle bit that starts early shows up inside the window, and one that never starts shows up after it. The same paired reads in ESUSP catch a toggle bit that keeps running while the erase is suspended.

The timeout test sends a completion, a new start and a reset in that order. A design that cleared bit 5 on the wrong event would show it.

The suspend test runs a program inside ESUSP and then resumes the erase. A design that overwrote the erase context would leave bit 7 wrong after the resume.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_BUSY   = 3'd2,
        ST_TMO    = 3'd3,
        ST_ESUSP  = 3'd4,
        ST_SPROG  = 3'd5
    } st_e;

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int TMO_BIT  = 5;

endpackage

// File: rtl/opstat_settle.sv
module opstat_settle #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tog
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (adv) begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/opstat_fsm.sv
module opstat_fsm
    import opstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_erase,
    input  logic op_done,
    input  logic op_timeout,
    input  logic erase_susp,
    input  logic reset_cmd,
    input  logic settle_done,
    output st_e  st,
    output logic prog_ctx,
    output logic settle_load,
    output logic addr_load
);
    st_e nxt;

    // State register and program-context flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            prog_ctx <= 1'b0;
        end else begin
            st <= nxt;
            if (settle_load) begin
                prog_ctx <= ~op_erase;
            end else if (addr_load) begin
                prog_ctx <= 1'b1;
            end else if (st == ST_SPROG && nxt == ST_ESUSP) begin
                prog_ctx <= 1'b0;
            end
        end
    end

    // Next-state logic, one arm per named transition
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (op_start) nxt = ST_SETTLE;            // start
            end
            ST_SETTLE: begin
                if (op_timeout)       nxt = ST_TMO;       // time-out
                else if (op_done)     nxt = ST_IDLE;      // complete
                else if (settle_done) nxt = ST_BUSY;      // settle-expire
            end
            ST_BUSY: begin
                if (op_timeout)                    nxt = ST_TMO;   // time-out
                else if (op_done)                  nxt = ST_IDLE;  // complete
                else if (erase_susp && !prog_ctx)  nxt = ST_ESUSP; // suspend
            end
            ST_ESUSP: begin
                if (!erase_susp)                nxt = ST_BUSY;  // resume
                else if (op_start && !op_erase) nxt = ST_SPROG; // suspend-program
            end
            ST_SPROG: begin
                if (op_timeout)   nxt = ST_TMO;           // time-out
                else if (op_done) nxt = ST_ESUSP;         // suspend-program-complete
            end
            ST_TMO: begin
                if (reset_cmd) nxt = ST_IDLE;             // clear
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        settle_load = 1'b0;
        addr_load   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                settle_load = op_start;
                addr_load   = op_start && !op_erase;
            end
            ST_ESUSP: begin
                addr_load = erase_susp && op_start && !op_erase;
            end
            default: begin
                settle_load = 1'b0;
                addr_load   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/opstat_reporter.sv
module opstat_reporter
    import opstat_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int SETTLE_CYC = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic [AW-1:0] op_addr,
    input  logic          op_msb,
    input  logic          op_done,
    input  logic          op_timeout,
    input  logic          erase_susp,
    input  logic          reset_cmd,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          ready
);
    st_e           st;
    logic          prog_ctx;
    logic          settle_load;
    logic          addr_load;
    logic          settle_done;
    logic          tog;
    logic          tog_adv;
    logic [AW-1:0] addr_q;
    logic          msb_q;
    logic [DW-1:0] word;
    logic [DW-1:0] status;

    opstat_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_start   (op_start),
        .op_erase   (op_erase),
        .op_done    (op_done),
        .op_timeout (op_timeout),
        .erase_susp (erase_susp),
        .reset_cmd  (reset_cmd),
        .settle_done(settle_done),
        .st         (st),
        .prog_ctx   (prog_ctx),
        .settle_load(settle_load),
        .addr_load  (addr_load)
    );

    opstat_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (settle_load),
        .expired(settle_done)
    );

    assign tog_adv = rd_en && (st == ST_BUSY || st == ST_SPROG || st == ST_TMO);

    opstat_toggle u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (tog_adv),
        .tog  (tog)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            msb_q  <= 1'b0;
        end else if (addr_load) begin
            addr_q <= op_addr;
            msb_q  <= op_msb;
        end
    end

    always_comb begin
        status          = '0;
        status[TOG_BIT] = tog;
        status[TMO_BIT] = (st == ST_TMO);
        unique case (st)
            ST_IDLE: begin
                word = array_data;
            end
            ST_ESUSP: begin
                status[POLL_BIT] = 1'b1;
                word             = status;
            end
            default: begin
                status[POLL_BIT] = prog_ctx && (rd_addr == addr_q) && !msb_q;
                word             = status;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= word;
        end
    end

    assign ready = !(st == ST_SETTLE || st == ST_BUSY || st == ST_SPROG);

endmodule

// File: rtl/opstat_reporter_chk.sv
module opstat_reporter_chk
    import opstat_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input st_e           st,
    input logic          tog,
    input logic          prog_ctx,
    input logic          msb_q,
    input logic [AW-1:0] addr_q,
    input logic          op_start,
    input logic          reset_cmd,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] array_data,
    input logic [DW-1:0] rd_data,
    input logic          ready
);
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_IDLE) |=> rd_data == $past(array_data));

    p_dq7_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && st == ST_BUSY && prog_ctx && rd_addr == addr_q) |=> rd_data[POLL_BIT] == !$past(msb_q));

    p_tog_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SETTLE || st == ST_ESUSP) |=> $stable(tog));

    p_busy_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && op_start) |=> !ready);

    p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TMO && !reset_cmd) |=> st == ST_TMO);

    p_tmo_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TMO) |-> ready);

endmodule

bind opstat_reporter opstat_reporter_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .tog       (tog),
    .prog_ctx  (prog_ctx),
    .msb_q     (msb_q),
    .addr_q    (addr_q),
    .op_start  (op_start),
    .reset_cmd (reset_cmd),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .array_data(array_data),
    .rd_data   (rd_data),
    .ready     (ready)
);

// File: tb/opstat_reporter_test.sv
module opstat_reporter_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SETTLE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0, op_erase = 1'b0, op_msb = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          op_done = 1'b0, op_timeout = 1'b0, erase_susp = 1'b0, reset_cmd = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;
    logic          ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opstat_reporter #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .op_addr(op_addr), .op_msb(op_msb), .op_done(op_done),
        .op_timeout(op_timeout), .erase_susp(erase_susp), .reset_cmd(reset_cmd),
        .rd_en(rd_en), .rd_addr(rd_addr), .array_data(array_data),
        .rd_data(rd_data), .ready(ready)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, output logic [DW-1:0] d);
        rd_addr = a; array_data = arr; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_start(input logic erase, input logic [AW-1:0] a, input logic msb);
        op_start = 1'b1; op_erase = erase; op_addr = a; op_msb = msb;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic pulse_done();
        op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    endtask

    task automatic pulse_tmo();
        op_timeout = 1'b1; @(negedge clk); op_timeout = 1'b0;
    endtask

    task automatic pulse_rst();
        reset_cmd = 1'b1; @(negedge clk); reset_cmd = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 ready after reset", {7'd0, ready}, 8'd1);
        check("R12 rd_data after reset", rd_data, 8'h00);
    endtask

    task automatic t_idle();
        logic [DW-1:0] d;
        rd(16'h0040, 8'hA5, d);
        check("R1 idle pass-through", d, 8'hA5);
        idle(2);
        check("R1 rd_data holds", rd_data, 8'hA5);
        pulse_rst();
        check("R11 reset_cmd ignored in idle", {7'd0, ready}, 8'd1);
    endtask

    task automatic t_program();
        logic [DW-1:0] d1, d2;
        pulse_start(1'b0, 16'h0123, 1'b0);
        check("R7 busy after start", {7'd0, ready}, 8'd0);
        rd(16'h0123, 8'hFF, d1);
        rd(16'h0123, 8'hFF, d2);
        check("R2 dq7 inverse during settle", {7'd0, d1[7]}, 8'd1);
        check("R5 R6 dq6 frozen in settle", {7'd0, d1[6]}, {7'd0, d2[6]});
        check("R9 dq5 clear while running", {7'd0, d1[5]}, 8'd0);
        idle(SETTLE);
        check("R6 still busy after settle", {7'd0, ready}, 8'd0);
        rd(16'h0123, 8'hFF, d1);
        rd(16'h0123, 8'hFF, d2);
        check("R5 dq6 toggles in busy", {7'd0, d1[6] ^ d2[6]}, 8'd1);
        check("R2 dq7 inverse in busy", {7'd0, d2[7]}, 8'd1);
        rd(16'h0124, 8'hFF, d1);
        check("R3 other address dq7 zero", {7'd0, d1[7]}, 8'd0);
        pulse_start(1'b0, 16'h0200, 1'b1);
        rd(16'h0123, 8'hFF, d1);
        check("R11 start ignored while busy", {7'd0, d1[7]}, 8'd1);
        pulse_rst();
        check("R11 reset_cmd ignored while busy", {7'd0, ready}, 8'd0);
        pulse_done();
        check("R8 ready after completion", {7'd0, ready}, 8'd1);
        rd(16'h0123, 8'h3C, d1);
        check("R8 array data after completion", d1, 8'h3C);
    endtask

    task automatic t_program_msb1();
        logic [DW-1:0] d;
        pulse_start(1'b0, 16'h0010, 1'b1);
        idle(SETTLE + 2);
        rd(16'h0010, 8'h00, d);
        check("R2 dq7 inverse of one", {7'd0, d[7]}, 8'd0);
        pulse_done();
        rd(16'h0010, 8'h80, d);
        check("R8 true data after program", d, 8'h80);
    endtask

    task automatic t_early_done();
        pulse_start(1'b0, 16'h0011, 1'b0);
        idle(2);
        pulse_done();
        check("R6 completion honoured in settle", {7'd0, ready}, 8'd1);
    endtask

    task automatic t_erase_suspend();
        logic [DW-1:0] d1, d2;
        pulse_start(1'b1, 16'h0000, 1'b0);
        idle(SETTLE + 2);
        rd(16'h0300, 8'hFF, d1);
        rd(16'h0300, 8'hFF, d2);
        check("R4 dq7 zero in erase", {7'd0, d1[7]}, 8'd0);
        check("R5 dq6 toggles in erase", {7'd0, d1[6] ^ d2[6]}, 8'd1);
        erase_susp = 1'b1;
        @(negedge clk);
        check("R7 ready in erase suspend", {7'd0, ready}, 8'd1);
        rd(16'h0300, 8'h00, d1);
        rd(16'h0300, 8'h00, d2);
        check("R4 dq7 one in suspend", {7'd0, d1[7]}, 8'd1);
        check("R5 dq6 frozen in suspend", {7'd0, d1[6]}, {7'd0, d2[6]});
        pulse_start(1'b0, 16'h0456, 1'b0);
        check("R10 busy in suspend program", {7'd0, ready}, 8'd0);
        rd(16'h0456, 8'h00, d1);
        rd(16'h0456, 8'h00, d2);
        check("R10 dq7 inverse in suspend program", {7'd0, d1[7]}, 8'd1);
        check("R10 dq6 toggles in suspend program", {7'd0, d1[6] ^ d2[6]}, 8'd1);
        rd(16'h0457, 8'h00, d1);
        check("R10 other address zero", {7'd0, d1[7]}, 8'd0);
        pulse_done();
        check("R10 back to suspend", {7'd0, ready}, 8'd1);
        erase_susp = 1'b0;
        @(negedge clk);
        check("R10 resumed erase busy", {7'd0, ready}, 8'd0);
        rd(16'h0456, 8'hFF, d1);
        check("R10 dq7 zero after resume", {7'd0, d1[7]}, 8'd0);
        pulse_done();
        rd(16'h0456, 8'h5A, d1);
        check("R8 array after erase", d1, 8'h5A);
    endtask

    task automatic t_timeout();
        logic [DW-1:0] d;
        pulse_start(1'b0, 16'h0777, 1'b0);
        idle(SETTLE + 2);
        pulse_tmo();
        check("R9 ready on timeout", {7'd0, ready}, 8'd1);
        rd(16'h0777, 8'h00, d);
        check("R9 dq5 set", {7'd0, d[5]}, 8'd1);
        check("R2 dq7 inverse in timeout", {7'd0, d[7]}, 8'd1);
        pulse_done();
        pulse_start(1'b1, 16'h0000, 1'b0);
        rd(16'h0777, 8'h00, d);
        check("R9 dq5 sticky through done and start", {7'd0, d[5]}, 8'd1);
        check("R11 start ignored in timeout", {7'd0, ready}, 8'd1);
        pulse_rst();
        rd(16'h0777, 8'h66, d);
        check("R9 reset command clears", d, 8'h66);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_program();
        t_program_msb1();
        t_early_done();
        t_erase_suspend();
        t_timeout();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule